// File: doc/BRIEF.md
# Page Program Buffer with Programming Timer

This block sits behind the serial command decoder of a non-volatile memory. When a write command opens, the decoder hands it the start address. The data bytes of the command then arrive one at a time on a valid/ready stream. Each byte goes into a page-sized staging buffer. The buffer slot comes from the low address bits, which advance after every byte and wrap inside the page. The high address bits stay fixed for the whole command.

When chip select rises, the decoder reports whether the rise came exactly on a byte boundary. If it did and at least one byte was staged, the block walks the page once and writes every staged slot to the array port. It skips any address that the protection logic refuses. It then holds busy for a programming interval set by a parameter and counted in clock cycles. No erase pass is made before the writes. In the last busy cycle it pulses a completion strobe, which the surrounding logic uses to clear its write-enable latch. A command that ends off a byte boundary, or with no byte, is dropped: no busy period starts and nothing is written.

Stream rules: a byte is taken on a clock edge where `byte_valid` and `byte_ready` are both high. `byte_ready` is low for the whole busy period, so the sender must hold a byte until the busy period ends. Bytes offered while no command is open are accepted and then discarded.

Top module: `page_prog_buffer`

## Requirements
- R1: After reset, `busy`, `arr_we` and `cycle_done` are low and `byte_ready` is high.
- R2: The k-th byte of a command (k from 0) is stored for address {start high bits, (start low 6 bits + k) mod 64}. The high bits never change, even when the offset wraps from 63 to 0.
- R3: When more than 64 bytes arrive, a later byte for the same offset replaces the earlier one, and only the last value is written.
- R4: A chip-select rise with `cs_aligned` low, or with no byte accepted since the command opened, abandons the command: `busy` stays low and the array is not written.
- R5: After a committing chip-select rise, `busy` is high from the next cycle for exactly 64 + PROG_CYCLES cycles, and `byte_ready` is low in every busy cycle.
- R6: `cycle_done` is high for exactly one cycle per committed command, and that cycle is the last cycle in which `busy` is high.
- R7: A staged byte whose address is presented while `wr_allow` is low is not written, and the other staged bytes of the page are still written.
- R8: Array locations of the page whose offsets received no byte keep their previous contents.
- R9: While `busy` is high, `cmd_start` and offered bytes have no effect. A chip-select rise with no command open starts nothing.
- R10: Bytes offered while no command is open are discarded and never reach the array.
- R11: `arr_we` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: a write command opens, and cmd_addr is valid |
| cmd_addr | input | ADDR_W | Start address of the command |
| byte_valid | input | 1 | Stream valid for byte_data |
| byte_ready | output | 1 | Stream ready; low while busy |
| byte_data | input | DATA_W | Data byte |
| cs_rise | input | 1 | Pulse: chip select went high |
| cs_aligned | input | 1 | The chip-select rise came exactly on a byte boundary |
| wr_allow | input | 1 | Write permission for the address currently on arr_addr |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address, also the protection query address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Page write or programming interval in progress |
| cycle_done | output | 1 | One-cycle pulse in the final busy cycle |

## Verification
A committing chip-select rise sampled at clock edge P makes `busy` visible in the first sample after P. `busy` then stays high for 64 + PROG_CYCLES samples. `cycle_done` is due in the last of those samples and `busy` is low in the next one. The array writes all fall inside the first 64 busy cycles. The bench drives inputs just after a rising edge and samples on falling edges. It counts busy, completion and ready samples over a fixed window. Once the window closes, it compares a bench-side copy of the array against the contents expected from the requirements.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_PROG  = 2'd3
  } pwb_state_e;
endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);
  localparam int DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  full_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_off == OFF_W'(g));

    always_ff @(posedge clk) begin
      if (hit) slot_q[g] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   full_q[g] <= 1'b0;
      else if (clr) full_q[g] <= 1'b0;
      else if (hit) full_q[g] <= 1'b1;
    end
  end

  assign rd_data = slot_q[rd_off];
  assign rd_vld  = full_q[rd_off];
endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer #(
  parameter int CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic running,
  output logic last
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= CNT_W'(CYCLES - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign running = run_q;
  assign last    = run_q && (cnt_q == '0);
endmodule

// File: rtl/page_prog_buffer.sv
module page_prog_buffer #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int OFF_W       = 6,
  parameter int PROG_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              wr_allow,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              busy,
  output logic              cycle_done
);
  import pwb_pkg::*;

  localparam int PAGE_W = ADDR_W - OFF_W;

  pwb_state_e        state_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  idx_q;
  logic              got_q;

  logic              in_fill, in_flush, in_prog, in_idle;
  logic              accept, open_cmd, flush_end;
  logic              buf_vld;
  logic [DATA_W-1:0] buf_data;
  logic              tmr_run, tmr_last;

  assign in_idle  = (state_q == ST_IDLE);
  assign in_fill  = (state_q == ST_FILL);
  assign in_flush = (state_q == ST_FLUSH);
  assign in_prog  = (state_q == ST_PROG);

  assign byte_ready = !(in_flush || in_prog);
  assign accept     = in_fill && byte_valid && byte_ready;
  assign open_cmd   = in_idle && cmd_start;
  assign flush_end  = in_flush && (&idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      off_q   <= '0;
      idx_q   <= '0;
      got_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_start) begin
            page_q  <= cmd_addr[ADDR_W-1:OFF_W];
            off_q   <= cmd_addr[OFF_W-1:0];
            got_q   <= 1'b0;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (accept) begin
            off_q <= off_q + 1'b1;
            got_q <= 1'b1;
          end
          if (cs_rise) begin
            idx_q   <= '0;
            state_q <= (cs_aligned && (got_q || accept)) ? ST_FLUSH : ST_IDLE;
          end
        end
        ST_FLUSH: begin
          idx_q <= idx_q + 1'b1;
          if (flush_end) state_q <= ST_PROG;
        end
        ST_PROG: begin
          if (tmr_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pwb_page_buf #(
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W)
  ) buf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (open_cmd),
    .wr_en   (accept),
    .wr_off  (off_q),
    .wr_data (byte_data),
    .rd_off  (idx_q),
    .rd_data (buf_data),
    .rd_vld  (buf_vld)
  );

  pwb_prog_timer #(
    .CYCLES (PROG_CYCLES)
  ) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (flush_end),
    .running (tmr_run),
    .last    (tmr_last)
  );

  assign arr_addr   = {page_q, idx_q};
  assign arr_wdata  = buf_data;
  assign arr_we     = in_flush && buf_vld && wr_allow;
  assign busy       = in_flush || in_prog;
  assign cycle_done = in_prog && tmr_run && tmr_last;
endmodule

// File: rtl/page_prog_buffer_chk.sv
module page_prog_buffer_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_rise,
  input logic cs_aligned,
  input logic wr_allow,
  input logic byte_ready,
  input logic arr_we,
  input logic busy,
  input logic cycle_done
);
  // R11
  we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R7
  we_needs_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> wr_allow);

  // R5
  ready_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byte_ready);

  // R5
  busy_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise) && $past(cs_aligned));

  // R6
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> busy);

  // R6
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !busy && !cycle_done);

  // R6
  busy_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cycle_done));

  // R4
  unaligned_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !cs_aligned && !busy) |=> !busy);
endmodule

bind page_prog_buffer page_prog_buffer_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_rise    (cs_rise),
  .cs_aligned (cs_aligned),
  .wr_allow   (wr_allow),
  .byte_ready (byte_ready),
  .arr_we     (arr_we),
  .busy       (busy),
  .cycle_done (cycle_done)
);

// File: tb/page_prog_buffer_tb_top.sv
module page_prog_buffer_tb_top;
  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int OW    = 6;
  localparam int PG    = 1 << OW;
  localparam int PROG  = 20;
  localparam int MEMN  = 1 << AW;
  localparam int BUSYN = PG + PROG;
  localparam int WIN   = BUSYN + 16;

  typedef struct packed {
    logic [AW-1:0] start;
    logic [7:0]    n;
    logic [7:0]    seed;
    logic          al;
    logic [AW:0]   prot;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{10'h040, 8'd64, 8'h10, 1'b1, 11'h400},
    '{10'h07E, 8'd3,  8'hA0, 1'b1, 11'h400},
    '{10'h080, 8'd70, 8'h30, 1'b1, 11'h400},
    '{10'h0C5, 8'd5,  8'h55, 1'b0, 11'h400},
    '{10'h0C0, 8'd0,  8'h66, 1'b1, 11'h400},
    '{10'h0C0, 8'd64, 8'h77, 1'b1, 11'h0E0},
    '{10'h3F0, 8'd20, 8'h99, 1'b1, 11'h400}
  };
  localparam string TAGS [NV] = '{"R8", "R2", "R3", "R4", "R4", "R7", "R2"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic byte_valid = 1'b0;
  logic byte_ready;
  logic [DW-1:0] byte_data = '0;
  logic cs_rise = 1'b0;
  logic cs_aligned = 1'b0;
  logic wr_allow;
  logic arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;
  logic busy;
  logic cycle_done;
  logic [AW:0] prot_lo = 11'h400;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] mem_m [MEMN];
  logic [DW-1:0] mem_e [MEMN];
  logic poke = 1'b0;

  always #4 clk = ~clk;

  assign wr_allow = ({1'b0, arr_addr} < prot_lo);

  page_prog_buffer #(
    .ADDR_W (AW), .DATA_W (DW), .OFF_W (OW), .PROG_CYCLES (PROG)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .cmd_start (cmd_start), .cmd_addr (cmd_addr),
    .byte_valid (byte_valid), .byte_ready (byte_ready), .byte_data (byte_data),
    .cs_rise (cs_rise), .cs_aligned (cs_aligned), .wr_allow (wr_allow),
    .arr_we (arr_we), .arr_addr (arr_addr), .arr_wdata (arr_wdata),
    .busy (busy), .cycle_done (cycle_done)
  );

  always @(negedge clk) if (arr_we) mem_m[arr_addr] <= arr_wdata;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_mem(input string tag);
    int bad = 0;
    int first = -1;
    for (int a = 0; a < MEMN; a++)
      if (mem_m[a] !== mem_e[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    if (first < 0) check(1'b1, tag, "array", 0, 0);
    else check(1'b0, tag, $sformatf("array @%0h", first), int'(mem_m[first]), int'(mem_e[first]));
  endtask

  // Sample WIN falling edges; returns busy count, done count, done index, last busy index, ready faults.
  task automatic watch(output int nb, output int nd, output int di, output int lb,
                       output int rf, output int fb);
    nb = 0; nd = 0; di = -1; lb = -1; rf = 0; fb = -1;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (poke && i == 10) begin
        cmd_start = 1'b1; cmd_addr = 10'h200; byte_valid = 1'b1; byte_data = 8'h5A;
      end
      if (poke && i == 12) begin
        cmd_start = 1'b0; byte_valid = 1'b0;
      end
      if (busy) begin
        nb++; lb = i;
        if (fb < 0) fb = i;
        if (byte_ready) rf++;
      end
      if (cycle_done) begin nd++; di = i; end
    end
  endtask

  task automatic run_cmd(input vec_t v, input string tag);
    logic [DW-1:0] eb [PG];
    bit ev [PG];
    int nb, nd, di, lb, rf, fb;
    bit commit;
    for (int o = 0; o < PG; o++) ev[o] = 1'b0;
    prot_lo = v.prot;
    cmd_start = 1'b1; cmd_addr = v.start;
    @(posedge clk); #1 cmd_start = 1'b0;
    for (int k = 0; k < int'(v.n); k++) begin
      logic [DW-1:0] d;
      int o;
      d = v.seed + 8'(k * 7);
      o = (int'(v.start[OW-1:0]) + k) % PG;
      eb[o] = d; ev[o] = 1'b1;
      byte_valid = 1'b1; byte_data = d;
      @(posedge clk); #1;
    end
    byte_valid = 1'b0;
    cs_rise = 1'b1; cs_aligned = v.al;
    @(posedge clk); #1 cs_rise = 1'b0; cs_aligned = 1'b0;
    commit = v.al && (v.n != 0);
    if (commit)
      for (int o = 0; o < PG; o++)
        if (ev[o]) begin
          int a;
          a = int'({v.start[AW-1:OW], 6'(o)});
          if (a < int'(v.prot)) mem_e[a] = eb[o];
        end
    watch(nb, nd, di, lb, rf, fb);
    if (commit) begin
      check(nb == BUSYN && fb == 0, "R5", {tag, " busy length"}, nb, BUSYN);
      check(nd == 1 && di == lb, "R6", {tag, " done on last busy"}, di, lb);
    end else begin
      check(nb == 0, "R4", {tag, " busy after abandon"}, nb, 0);
      check(nd == 0, "R4", {tag, " done after abandon"}, nd, 0);
    end
    check(rf == 0, "R5", {tag, " ready while busy"}, rf, 0);
    cmp_mem(tag);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int nb, nd, di, lb, rf, fb;
    for (int a = 0; a < MEMN; a++) begin mem_m[a] = '0; mem_e[a] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!busy && !arr_we && !cycle_done && byte_ready, "R1", "reset outputs",
          int'({busy, arr_we, cycle_done, byte_ready}), 1);

    for (int v = 0; v < NV; v++) run_cmd(VECS[v], TAGS[v]);

    // R10: bytes offered with no open command are dropped
    @(posedge clk); #1;
    for (int k = 0; k < 4; k++) begin
      byte_valid = 1'b1; byte_data = 8'hC0 + 8'(k);
      @(posedge clk); #1;
    end
    byte_valid = 1'b0;
    run_cmd('{10'h100, 8'd1, 8'hEE, 1'b1, 11'h400}, "R10");

    // R9: command and bytes during busy are ignored, stray cs rise starts nothing
    poke = 1'b1;
    run_cmd('{10'h180, 8'd2, 8'h42, 1'b1, 11'h400}, "R9");
    poke = 1'b0;
    @(posedge clk); #1 cs_rise = 1'b1; cs_aligned = 1'b1;
    @(posedge clk); #1 cs_rise = 1'b0; cs_aligned = 1'b0;
    watch(nb, nd, di, lb, rf, fb);
    check(nb == 0 && nd == 0, "R9", "stray cs rise", nb, 0);
    // R11: array untouched outside committed commands
    cmp_mem("R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule